// File: doc/BRIEF.md
# Processor Sleep Mode Controller

This block sequences a processor core between full operation and three low-power modes of increasing depth: a light doze, a nap and a full sleep. Software asks for a mode through a one-cycle request that carries a 2-bit mode code, a flag that lets sleep also stop the PLL, and a timeout value. The controller then gates the clock enables for the core units, the cache, the main clock and the PLL. A deeper mode turns off more of these and accepts fewer wake events. Its wake sequence is also longer.

A light doze stops only the core units, so the cache stays clocked and keeps coherency. A nap also stops the cache, but the PLL stays on. A doze or a nap ends on an external interrupt or when its timeout runs out. A sleep stops the main clock and ends only on an interrupt. When sleep was also told to stop the PLL, the wake sequence turns the PLL on first. It waits a fixed relock time and then for the lock indication, and only then restores the clocks. A `ready` output marks the cycles in which the core may run.

Top module: `pmc_sleep_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the controller is in run: all four enables are high and `ready` is high.
- R2: A request is accepted in run when `req_valid` is high and `req_mode` is 1 (doze), 2 (nap) or 3 (sleep). Code 0 has no effect. After an accepted request, `ready` is low from the next cycle. An entry phase of ENTER_CYC cycles follows, with all clocks still on.
- R3: An interrupt sampled during the entry phase aborts the entry, and the controller is back in run after that edge.
- R4: In doze the core enable is low, and the cache, PLL and main clock enables are high.
- R5: In nap the core and cache enables are low, and the PLL and main clock enables are high.
- R6: In sleep the core, cache and main clock enables are low. The PLL enable is high, unless the request carried the PLL-off flag, in which case it is low as well.
- R7: In doze or nap with a timeout value T greater than 0, the mode lasts T cycles and then wake starts. T equal to 0 disables the timeout.
- R8: An interrupt ends doze, nap and sleep. The timeout value has no effect in sleep.
- R9: A wake sequence keeps the core enable low and `ready` low for WAKE_DOZE, WAKE_NAP or WAKE_SLEEP cycles, according to the mode being left. It then returns to run.
- R10: On wake from a PLL-off sleep, only the PLL enable is high for RELOCK_CYC cycles. After that, the controller keeps waiting until `pll_lock` is high, and then runs the sleep wake sequence.
- R11: A request that arrives while the controller is not in run is ignored.
- R12: `ready` is high exactly when the controller is in run, and it is low from the cycle after acceptance until the wake sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode: 0 none, 1 doze, 2 nap, 3 sleep |
| req_pll_off | input | 1 | Sleep also stops the PLL |
| tmo_limit | input | TMO_W | Timeout in cycles for doze or nap, 0 for none |
| irq | input | 1 | External interrupt (wake event) |
| pll_lock | input | 1 | PLL lock indication |
| core_clk_en | output | 1 | Clock enable for the core units |
| cache_clk_en | output | 1 | Clock enable for the on-chip cache |
| pll_en | output | 1 | PLL enable |
| main_clk_en | output | 1 | Main clock enable |
| ready | output | 1 | Core may execute |

## Verification
The hardest situation to reach from the ports is a PLL-off wake in which lock is still missing after the relock count has expired. The bench's lock model follows `pll_en`, and a force input holds lock low through the whole relock window and beyond it. While lock is held low, the bench samples the enables. It then releases lock at a chosen cycle and counts the cycles until `ready` rises. Two other cases need careful timing. An entry is aborted by placing an interrupt on the first entry edge. A request is injected halfway through a doze to show that it is dropped.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_ENTER,
    ST_DOZE,
    ST_NAP,
    ST_SLEEP,
    ST_SLPOFF,
    ST_RELOCK,
    ST_RESUME
  } pmc_state_e;

  typedef enum logic [1:0] {
    MD_NONE  = 2'd0,
    MD_DOZE  = 2'd1,
    MD_NAP   = 2'd2,
    MD_SLEEP = 2'd3
  } pmc_mode_e;

  typedef struct packed {
    logic core;
    logic cache;
    logic pll;
    logic main;
  } pmc_en_t;

endpackage

// File: rtl/pmc_seqcnt.sv
module pmc_seqcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (dec & (cnt_q != '0));
    cnt_d  = load ? load_val : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/pmc_outdec.sv
module pmc_outdec
  import pmc_pkg::*;
(
  input  pmc_state_e state,
  output pmc_en_t    en,
  output logic       ready
);

  always_comb begin
    ready = 1'b0;
    unique case (state)
      ST_RUN:    begin en = 4'b1111; ready = 1'b1; end
      ST_ENTER:  en = 4'b1111;
      ST_DOZE:   en = 4'b0111;
      ST_NAP:    en = 4'b0011;
      ST_SLEEP:  en = 4'b0010;
      ST_SLPOFF: en = 4'b0000;
      ST_RELOCK: en = 4'b0010;
      ST_RESUME: en = 4'b0111;
      default:   en = 4'b1111;
    endcase
  end

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int TMO_W      = 8,
  parameter int SEQ_W      = 9,
  parameter int ENTER_CYC  = 3,
  parameter int WAKE_DOZE  = 2,
  parameter int WAKE_NAP   = 5,
  parameter int WAKE_SLEEP = 10,
  parameter int RELOCK_CYC = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_mode,
  input  logic             req_pll_off,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             irq,
  input  logic             pll_lock,
  input  logic             seq_zero,
  output pmc_state_e       state,
  output logic             seq_load,
  output logic [SEQ_W-1:0] seq_val,
  output logic             seq_dec
);

  localparam logic [SEQ_W-1:0] V_ENTER  = SEQ_W'(ENTER_CYC - 1);
  localparam logic [SEQ_W-1:0] V_WDOZE  = SEQ_W'(WAKE_DOZE - 1);
  localparam logic [SEQ_W-1:0] V_WNAP   = SEQ_W'(WAKE_NAP - 1);
  localparam logic [SEQ_W-1:0] V_WSLEEP = SEQ_W'(WAKE_SLEEP - 1);
  localparam logic [SEQ_W-1:0] V_RELOCK = SEQ_W'(RELOCK_CYC - 1);

  pmc_state_e       st_q, st_d;
  pmc_mode_e        tgt_q;
  logic             off_q;
  logic             armed_q;
  logic [TMO_W-1:0] lim_q;
  logic             accept;
  logic [SEQ_W-1:0] lim_ext;
  logic [SEQ_W-1:0] wake_val;

  assign lim_ext  = {{(SEQ_W-TMO_W){1'b0}}, lim_q};
  assign wake_val = (st_q == ST_NAP) ? V_WNAP : V_WDOZE;

  // next state
  always_comb begin
    st_d     = st_q;
    seq_load = 1'b0;
    seq_val  = '0;
    seq_dec  = 1'b0;
    accept   = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (req_valid && (req_mode != MD_NONE)) begin
          accept   = 1'b1;
          st_d     = ST_ENTER;
          seq_load = 1'b1;
          seq_val  = V_ENTER;
        end
      end
      ST_ENTER: begin
        if (irq) begin
          st_d = ST_RUN;
        end else if (seq_zero) begin
          seq_load = 1'b1;
          seq_val  = armed_q ? (lim_ext - SEQ_W'(1)) : '0;
          unique case (tgt_q)
            MD_NAP:   st_d = ST_NAP;
            MD_SLEEP: st_d = off_q ? ST_SLPOFF : ST_SLEEP;
            default:  st_d = ST_DOZE;
          endcase
        end else begin
          seq_dec = 1'b1;
        end
      end
      ST_DOZE, ST_NAP: begin
        if (irq || (armed_q && seq_zero)) begin
          st_d     = ST_RESUME;
          seq_load = 1'b1;
          seq_val  = wake_val;
        end else begin
          seq_dec = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (irq) begin
          st_d     = ST_RESUME;
          seq_load = 1'b1;
          seq_val  = V_WSLEEP;
        end
      end
      ST_SLPOFF: begin
        if (irq) begin
          st_d     = ST_RELOCK;
          seq_load = 1'b1;
          seq_val  = V_RELOCK;
        end
      end
      ST_RELOCK: begin
        if (seq_zero) begin
          if (pll_lock) begin
            st_d     = ST_RESUME;
            seq_load = 1'b1;
            seq_val  = V_WSLEEP;
          end
        end else begin
          seq_dec = 1'b1;
        end
      end
      ST_RESUME: begin
        if (seq_zero) st_d = ST_RUN;
        else          seq_dec = 1'b1;
      end
      default: st_d = ST_RUN;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= MD_NONE;
      off_q   <= 1'b0;
      armed_q <= 1'b0;
      lim_q   <= '0;
    end else if (accept) begin
      tgt_q   <= pmc_mode_e'(req_mode);
      off_q   <= req_pll_off;
      armed_q <= (tmo_limit != '0);
      lim_q   <= tmo_limit;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/pmc_sleep_ctrl.sv
module pmc_sleep_ctrl
  import pmc_pkg::*;
#(
  parameter int TMO_W      = 8,
  parameter int ENTER_CYC  = 3,
  parameter int WAKE_DOZE  = 2,
  parameter int WAKE_NAP   = 5,
  parameter int WAKE_SLEEP = 10,
  parameter int RELOCK_CYC = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_mode,
  input  logic             req_pll_off,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             irq,
  input  logic             pll_lock,
  output logic             core_clk_en,
  output logic             cache_clk_en,
  output logic             pll_en,
  output logic             main_clk_en,
  output logic             ready
);

  localparam int M_A     = (RELOCK_CYC > WAKE_SLEEP) ? RELOCK_CYC : WAKE_SLEEP;
  localparam int M_B     = (WAKE_NAP > WAKE_DOZE) ? WAKE_NAP : WAKE_DOZE;
  localparam int M_C     = (M_A > M_B) ? M_A : M_B;
  localparam int M_D     = (M_C > ENTER_CYC) ? M_C : ENTER_CYC;
  localparam int TMO_MAX = 1 << TMO_W;
  localparam int SEQ_MAX = (M_D > TMO_MAX) ? M_D : TMO_MAX;
  localparam int SEQ_W   = $clog2(SEQ_MAX + 1);

  pmc_state_e       state;
  logic             seq_load;
  logic             seq_dec;
  logic             seq_zero;
  logic [SEQ_W-1:0] seq_val;
  pmc_en_t          en;

  pmc_fsm #(
    .TMO_W(TMO_W), .SEQ_W(SEQ_W), .ENTER_CYC(ENTER_CYC),
    .WAKE_DOZE(WAKE_DOZE), .WAKE_NAP(WAKE_NAP),
    .WAKE_SLEEP(WAKE_SLEEP), .RELOCK_CYC(RELOCK_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_mode(req_mode),
    .req_pll_off(req_pll_off), .tmo_limit(tmo_limit),
    .irq(irq), .pll_lock(pll_lock), .seq_zero(seq_zero),
    .state(state), .seq_load(seq_load), .seq_val(seq_val),
    .seq_dec(seq_dec)
  );

  pmc_seqcnt #(.W(SEQ_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(seq_load), .load_val(seq_val),
    .dec(seq_dec), .zero(seq_zero)
  );

  pmc_outdec u_dec (.state(state), .en(en), .ready(ready));

  assign core_clk_en  = en.core;
  assign cache_clk_en = en.cache;
  assign pll_en       = en.pll;
  assign main_clk_en  = en.main;

endmodule

// File: rtl/pmc_sleep_ctrl_chk.sv
module pmc_sleep_ctrl_chk #(
  parameter int TMO_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_mode,
  input logic             req_pll_off,
  input logic [TMO_W-1:0] tmo_limit,
  input logic             irq,
  input logic             pll_lock,
  input logic             core_clk_en,
  input logic             cache_clk_en,
  input logic             pll_en,
  input logic             main_clk_en,
  input logic             ready
);

  p_ready_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (core_clk_en && cache_clk_en && pll_en && main_clk_en));

  p_main_pll_r6: assert property (@(posedge clk) disable iff (!rst_n)
    main_clk_en |-> pll_en);

  p_core_cache_r4: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |-> cache_clk_en);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid && (req_mode != 2'd0)) |=> !ready);

  p_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && core_clk_en && irq) |=> ready);

  p_relock_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_clk_en) |-> $past(pll_en));

  p_core_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> ready);

endmodule

bind pmc_sleep_ctrl pmc_sleep_ctrl_chk #(.TMO_W(TMO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .req_pll_off(req_pll_off), .tmo_limit(tmo_limit), .irq(irq),
  .pll_lock(pll_lock), .core_clk_en(core_clk_en),
  .cache_clk_en(cache_clk_en), .pll_en(pll_en),
  .main_clk_en(main_clk_en), .ready(ready)
);

// File: tb/sim_pmc_sleep_ctrl.sv
module sim_pmc_sleep_ctrl;

  localparam int E = 3;

  typedef struct packed {
    logic [1:0]  md;
    logic        off;
    logic [7:0]  lim;
    logic [15:0] irq_at;
    logic [15:0] samp_at;
    logic [3:0]  en;
    logic [15:0] len;
  } vec_t;

  // en = {core, cache, pll, main}
  localparam vec_t VECS [8] = '{
    '{2'd1, 1'b0, 8'd4,   16'd0,  16'd3,  4'b0111, 16'd9},   // R4 R7
    '{2'd2, 1'b0, 8'd6,   16'd0,  16'd3,  4'b0011, 16'd14},  // R5 R7
    '{2'd1, 1'b0, 8'd0,   16'd8,  16'd3,  4'b0111, 16'd10},  // R8 R9
    '{2'd2, 1'b0, 8'd0,   16'd5,  16'd3,  4'b0011, 16'd10},  // R8 R9
    '{2'd3, 1'b0, 8'd3,   16'd20, 16'd10, 4'b0010, 16'd30},  // R6 R8
    '{2'd3, 1'b1, 8'd0,   16'd6,  16'd3,  4'b0000, 16'd216}, // R6 R10
    '{2'd2, 1'b0, 8'd1,   16'd0,  16'd3,  4'b0011, 16'd9},   // R7
    '{2'd1, 1'b0, 8'd200, 16'd10, 16'd3,  4'b0111, 16'd12}   // R7 R8
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] req_mode;
  logic       req_pll_off;
  logic [7:0] tmo_limit;
  logic       irq;
  logic       lock_force;
  logic       pll_lock;
  logic       core_clk_en, cache_clk_en, pll_en, main_clk_en, ready;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  assign pll_lock = lock_force ? 1'b0 : pll_en;

  pmc_sleep_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_pll_off(req_pll_off), .tmo_limit(tmo_limit), .irq(irq),
    .pll_lock(pll_lock), .core_clk_en(core_clk_en),
    .cache_clk_en(cache_clk_en), .pll_en(pll_en),
    .main_clk_en(main_clk_en), .ready(ready)
  );

  function automatic logic [3:0] ens();
    return {core_clk_en, cache_clk_en, pll_en, main_clk_en};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Issue a request, then drive irq, a stray request and lock release
  // at given cycles; return enables seen at samp_at and cycles until ready.
  task automatic run_req(input logic [1:0] md, input logic off,
                         input logic [7:0] lim, input int irq_at,
                         input int inj_at, input int samp_at,
                         input int rel_at,
                         output logic [3:0] en_seen, output logic rdy0,
                         output int len);
    int c;
    en_seen = 'x;
    @(negedge clk);
    req_valid = 1'b1; req_mode = md; req_pll_off = off; tmo_limit = lim;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rdy0 = ready;
    c = 0;
    len = -1;
    while (c < 3000) begin
      irq = (irq_at != 0) && (c == irq_at - 1);
      req_valid = (inj_at != 0) && (c == inj_at);
      if (req_valid) begin
        req_mode = 2'd3; req_pll_off = 1'b1; tmo_limit = 8'd1;
      end
      if (rel_at != 0 && c == rel_at) lock_force = 1'b0;
      @(posedge clk);
      c++;
      @(negedge clk);
      irq = 1'b0;
      req_valid = 1'b0;
      if (c == samp_at) en_seen = ens();
      if (ready) begin
        len = c;
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] en_s;
    logic       r0;
    int         ln;
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'd0; req_pll_off = 1'b0;
    tmo_limit = 8'd0; irq = 1'b0; lock_force = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 enables in reset", 32'(ens()), 32'hF);
    chk("R1 ready in reset", 32'(ready), 32'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 ready after reset", 32'(ready), 32'd1);

    // vector table
    for (int i = 0; i < 8; i++) begin
      run_req(VECS[i].md, VECS[i].off, VECS[i].lim, int'(VECS[i].irq_at),
              0, int'(VECS[i].samp_at), 0, en_s, r0, ln);
      chk("R12 ready drops after accept", 32'(r0), 32'd0);
      chk("R4,R5,R6 mode enables", 32'(en_s), 32'(VECS[i].en));
      chk("R7,R8,R9,R10 ready-low length", 32'(ln), 32'(VECS[i].len));
      repeat (2) @(negedge clk);
    end

    // R2: mode code 0 is ignored
    @(negedge clk);
    req_valid = 1'b1; req_mode = 2'd0; tmo_limit = 8'd5;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R2 code 0 keeps ready", 32'(ready), 32'd1);
    chk("R2 code 0 keeps enables", 32'(ens()), 32'hF);

    // R2: entry phase has all clocks on
    run_req(2'd1, 1'b0, 8'd0, 6, 0, 2, 0, en_s, r0, ln);
    chk("R2 entry clocks on", 32'(en_s), 32'hF);
    chk("R9 doze wake length", 32'(ln), 32'd8);
    repeat (2) @(negedge clk);

    // R3: interrupt on first entry edge aborts
    run_req(2'd2, 1'b0, 8'd0, 1, 0, 0, 0, en_s, r0, ln);
    chk("R3 abort returns at once", 32'(ln), 32'd1);
    chk("R3 enables after abort", 32'(ens()), 32'hF);
    repeat (2) @(negedge clk);

    // R11: request during doze is dropped
    run_req(2'd1, 1'b0, 8'd0, 9, 5, 7, 0, en_s, r0, ln);
    chk("R11 stays in doze", 32'(en_s), 32'h7);
    chk("R11 doze wake kept", 32'(ln), 32'd11);
    repeat (2) @(negedge clk);

    // R10: lock missing past relock count
    lock_force = 1'b1;
    run_req(2'd3, 1'b1, 8'd0, 5, 0, 209, 220, en_s, r0, ln);
    chk("R10 waiting for lock enables", 32'(en_s), 32'h2);
    chk("R10 wake after lock", 32'(ln), 32'd231);
    lock_force = 1'b0;
    repeat (2) @(negedge clk);

    // R1: reset during nap returns to run at once
    run_req(2'd2, 1'b0, 8'd0, 0, 0, 0, 0, en_s, r0, ln);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset mid-nap enables", 32'(ens()), 32'hF);
    chk("R1 reset mid-nap ready", 32'(ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule